// File: doc/BRIEF.md
# Pipeline Abort Tagging and Exception Unit

This unit follows memory faults through a short in-order pipeline and decides when an abort exception is actually taken. When a fetch reports a fault, the unit does not trap at once. It marks the fetched instruction with a fault tag and a cause code, and moves that tag down a chain of stage registers in step with the pipeline. The tag is acted on only when the instruction reaches execute. A flush from a taken branch removes the tags, so a faulting instruction that never executes raises nothing.

Data faults are reported one cycle after execute, in the memory-access cycle. They count only for an instruction that passed its condition check in execute and was not interrupted there. When a data abort is taken, the unit cancels any base-register writeback that the load/store asked for in that same cycle. The register therefore keeps the value it had before the instruction. For either kind of abort, the unit registers a one-cycle request and a pipeline flush. It also captures a link address, the saved status, a fault status code and a fault address. It then refuses further aborts until the exception entry is acknowledged.

Top module: `abt_unit`

## Requirements
- R1: `fsr_out` holds `{kind, cause}` of the last abort taken: bit 2 is 0 for a fetch fault and 1 for a data fault. Bits 1:0 are the cause: 1 = permission fault, 2 = bus error response, 3 = ECC error.
- R2: A fetch fault presented with `if_valid` causes no request until the instruction reaches execute. With `adv` held high, `pabt_req` is seen STAGES+1 cycles after the fetch cycle.
- R3: A tagged instruction that is removed by `br_flush` before or during its execute cycle raises no exception.
- R4: A memory instruction that passes its condition in execute and gets `d_fault` in the next cycle raises `dabt_req` one cycle after the fault.
- R5: An abort is not taken for an instruction that fails its condition code (data access) or has `ex_irq` high in execute (data access or tagged fetch).
- R6: `base_wb_cancel` is high in the very cycle a data abort is accepted, if that instruction asked for base writeback, and is low in every other cycle.
- R7: `lr_out` is the faulting instruction address + 4 for a prefetch abort and + 8 for a data abort. `far_out` is the instruction address (prefetch) or `d_addr` (data).
- R8: `spsr_out` holds the `ex_status` value that was presented while the faulting instruction was in execute.
- R9: A data abort and a prefetch tag at execute in the same cycle: the data abort is taken and the younger tagged instruction is discarded without a later prefetch abort.
- R10: `pabt_req`/`dabt_req` last one cycle and are never high together. `pipe_flush` is high in exactly the same cycle.
- R11: After an abort is taken, no further abort is accepted until `exc_ack` has been seen. A data fault arriving in that window raises nothing and does not cancel writeback.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Pipeline advances this cycle |
| br_flush | input | 1 | Taken branch: discard all fetch-to-execute tags |
| if_valid | input | 1 | Fetch delivers an instruction |
| if_pc | input | AW | Address of fetched instruction |
| if_fault | input | 1 | Fetch reported a fault |
| if_cause | input | 2 | Fetch fault cause |
| ex_mem | input | 1 | Instruction in execute is a load/store |
| ex_cond_pass | input | 1 | Instruction in execute passes its condition |
| ex_irq | input | 1 | Interrupt taken on instruction in execute |
| ex_base_wb | input | 1 | Load/store requests base writeback |
| ex_status | input | SW | Processor status during execute |
| d_fault | input | 1 | Data access fault (memory-access cycle) |
| d_cause | input | 2 | Data fault cause |
| d_addr | input | AW | Data fault address |
| exc_ack | input | 1 | Exception entry acknowledged |
| pabt_req | output | 1 | Prefetch abort request pulse |
| dabt_req | output | 1 | Data abort request pulse |
| pipe_flush | output | 1 | Pipeline flush pulse |
| base_wb_cancel | output | 1 | Suppress base writeback this cycle |
| lr_out | output | AW | Captured link address |
| spsr_out | output | SW | Captured saved status |
| fsr_out | output | 3 | Captured fault kind and cause |
| far_out | output | AW | Captured fault address |

## Verification
A prefetch abort is due STAGES+1 cycles after its fetch. A data abort is due two cycles after the execute cycle. `base_wb_cancel` is combinational and is sampled just after the fault is driven in the memory-access cycle. The driver stamps each expected abort with the cycle in which it must appear, counted in rising edges. The monitor samples the registered outputs at the falling edge and compares both the contents and the stamp. Any request that comes with nothing queued, comes early, comes late or comes twice in a row is reported.

// File: rtl/abt_pkg.sv
package abt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PERM   = 2'd1,
    FLT_BUSERR = 2'd2,
    FLT_ECC    = 2'd3
  } flt_cause_e;

  localparam int unsigned LINK_OFS_FETCH = 4;
  localparam int unsigned LINK_OFS_DATA  = 8;

  // fault status code: kind in the top bit, cause below
  function automatic logic [2:0] status_code(input logic from_data, input flt_cause_e c);
    return {from_data, c};
  endfunction
endpackage

// File: rtl/abt_tag_pipe.sv
module abt_tag_pipe #(
  parameter int AW     = 32,
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          kill,
  input  logic          if_valid,
  input  logic          if_fault,
  input  logic [1:0]    if_cause,
  input  logic [AW-1:0] if_pc,
  output logic          ex_valid,
  output logic          ex_fault,
  output logic [1:0]    ex_cause,
  output logic [AW-1:0] ex_pc,
  output logic          tags_empty
);
  localparam int EX = STAGES - 1;

  logic          st_v  [STAGES];
  logic          st_f  [STAGES];
  logic [1:0]    st_c  [STAGES];
  logic [AW-1:0] st_pc [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic          nv, nf;
      logic [1:0]    nc;
      logic [AW-1:0] npc;
      if (i == 0) begin : g_head
        assign nv  = if_valid;
        assign nf  = if_fault;
        assign nc  = if_cause;
        assign npc = if_pc;
      end else begin : g_body
        assign nv  = st_v[i-1];
        assign nf  = st_f[i-1];
        assign nc  = st_c[i-1];
        assign npc = st_pc[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v[i]  <= 1'b0;
          st_f[i]  <= 1'b0;
          st_c[i]  <= '0;
          st_pc[i] <= '0;
        end else if (kill) begin
          st_v[i]  <= 1'b0;
          st_f[i]  <= 1'b0;
        end else if (adv) begin
          st_v[i]  <= nv;
          st_f[i]  <= nf & nv;
          st_c[i]  <= nc;
          st_pc[i] <= npc;
        end
      end
    end
  endgenerate

  assign ex_valid = st_v[EX];
  assign ex_fault = st_f[EX];
  assign ex_cause = st_c[EX];
  assign ex_pc    = st_pc[EX];

  always_comb begin
    tags_empty = 1'b1;
    for (int k = 0; k < STAGES; k++) if (st_v[k]) tags_empty = 1'b0;
  end

  // R3 R9: a kill leaves no tag behind
  kill_empties_chk: assert property (@(posedge clk) disable iff (!rst_n) kill |=> tags_empty);
endmodule

// File: rtl/abt_exec_qual.sv
module abt_exec_qual #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          busy,
  input  logic          br_flush,
  input  logic          ex_valid,
  input  logic          ex_fault,
  input  logic [AW-1:0] ex_pc,
  input  logic          ex_mem,
  input  logic          ex_cond_pass,
  input  logic          ex_irq,
  input  logic          ex_base_wb,
  input  logic [SW-1:0] ex_status,
  input  logic          d_fault,
  output logic          pabt_take,
  output logic          dabt_take,
  output logic          base_wb_cancel,
  output logic [AW-1:0] mem_pc,
  output logic [SW-1:0] mem_status
);
  logic ex_live, pabt_cand, mem_load;
  logic mem_valid, mem_bwb;

  // instruction actually leaves execute this cycle
  assign ex_live   = ex_valid && adv && !br_flush && !ex_irq;
  assign pabt_cand = ex_live && ex_fault;
  assign mem_load  = ex_live && !ex_fault && ex_mem && ex_cond_pass;

  // older instruction in the memory cycle wins over the tag in execute
  assign dabt_take      = mem_valid && d_fault && !busy;
  assign pabt_take      = pabt_cand && !dabt_take && !busy;
  assign base_wb_cancel = dabt_take && mem_bwb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid  <= 1'b0;
      mem_bwb    <= 1'b0;
      mem_pc     <= '0;
      mem_status <= '0;
    end else begin
      mem_valid <= mem_load && !dabt_take;
      if (mem_load) begin
        mem_bwb    <= ex_base_wb;
        mem_pc     <= ex_pc;
        mem_status <= ex_status;
      end
    end
  end

  // R11
  busy_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(pabt_take || dabt_take));
  // R5
  mem_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(ex_cond_pass && !ex_irq && ex_mem));
endmodule

// File: rtl/abt_capture.sv
module abt_capture #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pabt_take,
  input  logic          dabt_take,
  input  logic [AW-1:0] ex_pc,
  input  logic [SW-1:0] ex_status,
  input  logic [1:0]    ex_cause,
  input  logic [AW-1:0] mem_pc,
  input  logic [SW-1:0] mem_status,
  input  logic [1:0]    d_cause,
  input  logic [AW-1:0] d_addr,
  input  logic          exc_ack,
  output logic          pabt_req,
  output logic          dabt_req,
  output logic          pipe_flush,
  output logic [AW-1:0] lr_out,
  output logic [SW-1:0] spsr_out,
  output logic [2:0]    fsr_out,
  output logic [AW-1:0] far_out,
  output logic          busy
);
  import abt_pkg::*;

  function automatic logic [AW-1:0] link_of(input logic [AW-1:0] pc, input logic from_data);
    return pc + (from_data ? AW'(LINK_OFS_DATA) : AW'(LINK_OFS_FETCH));
  endfunction

  logic take;
  assign take = pabt_take || dabt_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pabt_req   <= 1'b0;
      dabt_req   <= 1'b0;
      pipe_flush <= 1'b0;
      lr_out     <= '0;
      spsr_out   <= '0;
      fsr_out    <= '0;
      far_out    <= '0;
      busy       <= 1'b0;
    end else begin
      pabt_req   <= pabt_take;
      dabt_req   <= dabt_take;
      pipe_flush <= take;
      if (take) busy <= 1'b1;
      else if (exc_ack) busy <= 1'b0;
      if (dabt_take) begin
        lr_out   <= link_of(mem_pc, 1'b1);
        spsr_out <= mem_status;
        fsr_out  <= status_code(1'b1, flt_cause_e'(d_cause));
        far_out  <= d_addr;
      end else if (pabt_take) begin
        lr_out   <= link_of(ex_pc, 1'b0);
        spsr_out <= ex_status;
        fsr_out  <= status_code(1'b0, flt_cause_e'(ex_cause));
        far_out  <= ex_pc;
      end
    end
  end

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pabt_req || dabt_req) |=> !(pabt_req || dabt_req));
endmodule

// File: rtl/abt_unit.sv
module abt_unit #(
  parameter int AW     = 32,
  parameter int SW     = 8,
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          br_flush,
  input  logic          if_valid,
  input  logic [AW-1:0] if_pc,
  input  logic          if_fault,
  input  logic [1:0]    if_cause,
  input  logic          ex_mem,
  input  logic          ex_cond_pass,
  input  logic          ex_irq,
  input  logic          ex_base_wb,
  input  logic [SW-1:0] ex_status,
  input  logic          d_fault,
  input  logic [1:0]    d_cause,
  input  logic [AW-1:0] d_addr,
  input  logic          exc_ack,
  output logic          pabt_req,
  output logic          dabt_req,
  output logic          pipe_flush,
  output logic          base_wb_cancel,
  output logic [AW-1:0] lr_out,
  output logic [SW-1:0] spsr_out,
  output logic [2:0]    fsr_out,
  output logic [AW-1:0] far_out
);
  logic          ex_valid, ex_fault, tags_empty;
  logic [1:0]    ex_cause;
  logic [AW-1:0] ex_pc, mem_pc;
  logic [SW-1:0] mem_status;
  logic          pabt_take, dabt_take, busy, tag_kill;

  assign tag_kill = br_flush || pabt_take || dabt_take;

  abt_tag_pipe #(.AW(AW), .STAGES(STAGES)) u_tags (
    .clk(clk), .rst_n(rst_n), .adv(adv), .kill(tag_kill),
    .if_valid(if_valid), .if_fault(if_fault), .if_cause(if_cause), .if_pc(if_pc),
    .ex_valid(ex_valid), .ex_fault(ex_fault), .ex_cause(ex_cause), .ex_pc(ex_pc),
    .tags_empty(tags_empty)
  );

  abt_exec_qual #(.AW(AW), .SW(SW)) u_exec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .busy(busy), .br_flush(br_flush),
    .ex_valid(ex_valid), .ex_fault(ex_fault), .ex_pc(ex_pc),
    .ex_mem(ex_mem), .ex_cond_pass(ex_cond_pass), .ex_irq(ex_irq),
    .ex_base_wb(ex_base_wb), .ex_status(ex_status), .d_fault(d_fault),
    .pabt_take(pabt_take), .dabt_take(dabt_take), .base_wb_cancel(base_wb_cancel),
    .mem_pc(mem_pc), .mem_status(mem_status)
  );

  abt_capture #(.AW(AW), .SW(SW)) u_cap (
    .clk(clk), .rst_n(rst_n), .pabt_take(pabt_take), .dabt_take(dabt_take),
    .ex_pc(ex_pc), .ex_status(ex_status), .ex_cause(ex_cause),
    .mem_pc(mem_pc), .mem_status(mem_status), .d_cause(d_cause), .d_addr(d_addr),
    .exc_ack(exc_ack), .pabt_req(pabt_req), .dabt_req(dabt_req),
    .pipe_flush(pipe_flush), .lr_out(lr_out), .spsr_out(spsr_out),
    .fsr_out(fsr_out), .far_out(far_out), .busy(busy)
  );

  // R10
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pabt_req, dabt_req}));
  // R6
  cancel_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb_cancel |=> dabt_req);
  // R2
  pabt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pabt_req |-> $past(ex_valid && ex_fault));
  // R9
  flush_clears_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |-> tags_empty);
endmodule

// File: tb/sim_abt_unit.sv
module sim_abt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam int STAGES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv = 1'b1, br_flush = 1'b0;
  logic if_valid = 1'b0, if_fault = 1'b0;
  logic [AW-1:0] if_pc = '0;
  logic [1:0] if_cause = '0;
  logic ex_mem = 1'b0, ex_cond_pass = 1'b0, ex_irq = 1'b0, ex_base_wb = 1'b0;
  logic [SW-1:0] ex_status = '0;
  logic d_fault = 1'b0;
  logic [1:0] d_cause = '0;
  logic [AW-1:0] d_addr = '0;
  logic exc_ack = 1'b0;
  logic pabt_req, dabt_req, pipe_flush, base_wb_cancel;
  logic [AW-1:0] lr_out, far_out;
  logic [SW-1:0] spsr_out;
  logic [2:0] fsr_out;

  abt_unit #(.AW(AW), .SW(SW), .STAGES(STAGES)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct {
    bit            is_data;
    logic [AW-1:0] lr, far;
    logic [SW-1:0] spsr;
    logic [2:0]    fsr;
    int            due;
    string         tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // monitor
  bit prev_req = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pabt_req || dabt_req) begin
        if (prev_req) chk("R10 pulse", 1, 0);
        if (q.size() == 0) chk("R10 unexpected request", {pabt_req, dabt_req}, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " due cycle"}, cyc, e.due);
          chk({e.tag, " kind"}, {pabt_req, dabt_req}, e.is_data ? 2'b01 : 2'b10);
          chk("R10 flush", pipe_flush, 1);
          chk("R7 link", lr_out, e.lr);
          chk("R7 fault addr", far_out, e.far);
          chk("R1 status code", fsr_out, e.fsr);
          chk("R8 saved status", spsr_out, e.spsr);
        end
      end else begin
        if (pipe_flush) chk("R10 flush alone", 1, 0);
        if (q.size() > 0 && cyc > q[0].due) begin
          chk({q[0].tag, " late"}, cyc, q[0].due);
          void'(q.pop_front());
        end
      end
      prev_req = pabt_req || dabt_req;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic ack();
    exc_ack = 1'b1; tick(); exc_ack = 1'b0;
  endtask

  task automatic push(bit is_data, logic [AW-1:0] lr, logic [AW-1:0] far,
                      logic [SW-1:0] sp, logic [2:0] fsr, int due, string tag);
    exp_t e;
    e.is_data = is_data; e.lr = lr; e.far = far; e.spsr = sp;
    e.fsr = fsr; e.due = due; e.tag = tag;
    q.push_back(e);
  endtask

  // fetch with fault; optional flush or irq before execute
  task automatic pabt_op(logic [AW-1:0] pc, logic [1:0] cause, logic [SW-1:0] st,
                         bit flush_it, bit irq_it, bit do_ack);
    int n;
    bit taken;
    n = cyc;
    taken = !flush_it && !irq_it;
    if_valid = 1; if_fault = 1; if_cause = cause; if_pc = pc;
    if (taken) push(0, pc + 4, pc, st, {1'b0, cause}, n + STAGES + 1, "R2");
    tick(); if_valid = 0; if_fault = 0;
    tick();
    if (flush_it) br_flush = 1;
    tick(); br_flush = 0;
    ex_status = st; ex_irq = irq_it;
    tick(); ex_status = '0; ex_irq = 0;
    if (!taken) chk(flush_it ? "R3 no abort" : "R5 irq no abort", pabt_req, 0);
    if (taken && do_ack) ack();
  endtask

  task automatic data_op(logic [AW-1:0] pc, logic [AW-1:0] addr, logic [1:0] cause,
                         logic [SW-1:0] st, bit cond, bit irq, bit bwb, bit blocked);
    int n;
    bit taken;
    n = cyc;
    taken = cond && !irq && !blocked;
    if_valid = 1; if_fault = 0; if_pc = pc;
    tick(); if_valid = 0;
    tick(); tick();
    ex_mem = 1; ex_cond_pass = cond; ex_irq = irq; ex_base_wb = bwb; ex_status = st;
    tick();
    ex_mem = 0; ex_cond_pass = 0; ex_irq = 0; ex_base_wb = 0; ex_status = '0;
    d_fault = 1; d_cause = cause; d_addr = addr;
    #1;
    chk("R6 base cancel", base_wb_cancel, taken && bwb);
    if (taken) push(1, pc + 8, addr, st, {1'b1, cause}, n + 5, "R4");
    tick(); d_fault = 0; d_cause = '0; d_addr = '0;
    if (!taken) chk(blocked ? "R11 blocked" : "R5 no abort", dabt_req, 0);
    if (taken) ack();
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 reset", {pabt_req, dabt_req, pipe_flush, base_wb_cancel}, 0);
    chk("R12 reset regs", {lr_out, far_out}, 0);
    chk("R12 reset status", {spsr_out, fsr_out}, 0);

    // R2 R1 R7 R8 deferred prefetch aborts, each cause
    pabt_op(32'h0000_0100, 2'd1, 8'h5A, 0, 0, 1);
    pabt_op(32'h0000_2000, 2'd2, 8'hC3, 0, 0, 1);
    pabt_op(32'h0000_3FFC, 2'd3, 8'h0F, 0, 0, 1);
    // R3 flushed tag
    pabt_op(32'h0000_0500, 2'd1, 8'h11, 1, 0, 1);
    // R5 interrupted tag
    pabt_op(32'h0000_0600, 2'd2, 8'h22, 0, 1, 1);

    // R4 R6 data aborts
    data_op(32'h0000_0200, 32'h8000_0040, 2'd2, 8'h77, 1, 0, 1, 0);
    data_op(32'h0000_0210, 32'h8000_1000, 2'd3, 8'h99, 1, 0, 0, 0);
    // R5 condition fail / interrupted
    data_op(32'h0000_0220, 32'h8000_2000, 2'd1, 8'h44, 0, 0, 1, 0);
    data_op(32'h0000_0230, 32'h8000_3000, 2'd1, 8'h45, 1, 1, 1, 0);

    // R9 same-cycle data abort vs younger tagged fetch
    n = cyc;
    if_valid = 1; if_fault = 0; if_pc = 32'h0000_0300;
    tick();
    if_fault = 1; if_cause = 2'd3; if_pc = 32'h0000_0304;
    tick(); if_valid = 0; if_fault = 0;
    tick();
    ex_mem = 1; ex_cond_pass = 1; ex_status = 8'h33;
    tick();
    ex_mem = 0; ex_cond_pass = 0; ex_status = '0;
    d_fault = 1; d_cause = 2'd2; d_addr = 32'h000D_EAD0;
    push(1, 32'h0000_0308, 32'h000D_EAD0, 8'h33, 3'b110, n + 5, "R9");
    tick(); d_fault = 0;
    ack();
    repeat (STAGES + 2) begin
      chk("R9 no late pabt", pabt_req, 0);
      tick();
    end

    // R11 lockout until acknowledge
    pabt_op(32'h0000_0700, 2'd1, 8'h66, 0, 0, 0);
    data_op(32'h0000_0710, 32'h9000_0000, 2'd2, 8'h67, 1, 0, 1, 1);
    ack();
    data_op(32'h0000_0720, 32'h9000_0100, 2'd3, 8'h68, 1, 0, 1, 0);

    repeat (4) tick();
    chk("R10 all expected seen", q.size(), 0);
    finish_sim();
  end
endmodule